// File: doc/BRIEF.md
# Scan-Cell Masking Unit with Bisecting Window Search

This block sits between the outputs of a set of parallel scan chains and the inputs of a multiple-input signature register in a logic self-test arrangement. Each shift cycle carries one bit per chain. A slice index counts the shift cycles of the current unload, starting at 1. A chain's bit reaches the signature register only when two conditions hold: the chain is marked in a per-chain selection register, and the current slice index lies inside an inclusive window `[win_lo, win_hi]`. Every other bit is driven to zero. The signature therefore covers only the chosen rectangle of scan cells.

A sequencer moves that window across repeated self-test sessions to find which slices hold erroneous cells. A search starts with the full window. At the end of each session the environment reports pass or fail. When a multi-slice window fails, the sequencer keeps its lower half as the next window and stacks the upper half. When a window passes, the sequencer takes the most recently stacked range. When a single-slice window fails, the sequencer reports that slice on a valid/ready result port. The next range is popped only after the report is accepted. When no range is left, the search is done.

The result port follows the usual rules. `hit_slice` is meaningful while `hit_valid` is high. The value is transferred on a clock edge where both `hit_valid` and `hit_ready` are high. While `hit_ready` is low, `hit_valid` and `hit_slice` hold and the sequencer does not advance. All other pins are plain level or pulse signals.

Top module: `scan_mask_unit`

## Requirements
- R1: After reset, `win_lo` = 1, `win_hi` = MAX_SLICE (7 by default), `busy` = 0, `search_done` = 0, `hit_valid` = 0, and every chain is selected.
- R2: `misr_in[c]` equals `chain_out[c]` only when `shift_en` is 1, bit c of the latched chain selection is 1, and `win_lo` <= slice <= `win_hi`. In every other case it is 0.
- R3: The slice index is set to 1 by `load_start` and rises by one after each `shift_en` cycle that has no `load_start`. It saturates at its all-ones value. A cycle is gated with the index held before that cycle's edge, so when `load_start` and `shift_en` coincide, that shift uses the old index and the next shift is slice 1.
- R4: `search_start` while `busy` is 0 latches `chain_pick` as the chain selection (bit c selects chain c). It sets the window to (1, MAX_SLICE), empties the pending stack, raises `busy` and clears `search_done`.
- R5: A `session_done` pulse with `session_fail` = 1 on a window with lo < hi makes the next window (lo, floor((lo+hi)/2)) and stacks (floor((lo+hi)/2)+1, hi).
- R6: A passing session, or an accepted report, makes the most recently stacked range the next window. If the stack is empty, `busy` falls and `search_done` rises, and both stay so until the next `search_start`.
- R7: A failing session on a single-slice window raises `hit_valid` with `hit_slice` equal to that slice. The pair holds, and the window does not move, until `hit_ready` is seen high.
- R8: `session_done` is ignored while no session is awaited, that is while idle, done or reporting.
- R9: Erroneous slices are reported in ascending order. A search takes 1 + 2×(number of failing multi-slice windows) sessions. For example, with erroneous slices {1,7} and MAX_SLICE = 7 it takes 9 sessions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_start | input | 1 | Restart the slice index at 1 |
| shift_en | input | 1 | A shift cycle is in progress |
| chain_out | input | NUM_CHAINS | One bit per scan chain in this shift |
| misr_in | output | NUM_CHAINS | Masked bits toward the signature register |
| chain_pick | input | NUM_CHAINS | Chain selection latched at search start |
| search_start | input | 1 | Begin a new bisecting search |
| session_done | input | 1 | Pulse: one self-test session has finished |
| session_fail | input | 1 | Signature of that session mismatched |
| win_lo | output | SLICE_W | Current lower slice bound (inclusive) |
| win_hi | output | SLICE_W | Current upper slice bound (inclusive) |
| busy | output | 1 | Search in progress |
| search_done | output | 1 | Search finished, stack empty |
| hit_valid | output | 1 | An erroneous slice is being reported |
| hit_ready | input | 1 | Consumer accepts the report |
| hit_slice | output | SLICE_W | Reported erroneous slice |

## Verification
Two cases are driven in the same cycle. In the first, a scan-load restart coincides with a shift: `load_start` and `shift_en` are raised together after the index has run past the window. The bench expects that cycle to stay masked under the old index and the very next shift to open as slice 1. In the second, a session-end pulse arrives while a hit report is stalled by back-pressure. The bench expects the window and the held report to stay unchanged. Whole searches are judged end to end. The bench places errors on one chain and noise on an unselected chain, derives each session's pass/fail only from the masked stream, and compares the session count and the reported slices against its own bisection arithmetic.

// File: rtl/scan_mask_pkg.sv
package scan_mask_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_RUN    = 2'd1,
    SQ_REPORT = 2'd2,
    SQ_DONE   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/slice_counter.sv
module slice_counter #(
  parameter int SLICE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic               step,
  output logic [SLICE_W-1:0] slice
);
  localparam logic [SLICE_W-1:0] FIRST = SLICE_W'(1);
  localparam logic [SLICE_W-1:0] TOP   = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slice <= FIRST;
    end else if (restart) begin
      slice <= FIRST;
    end else if (step && (slice != TOP)) begin
      slice <= slice + 1'b1;
    end
  end
endmodule

// File: rtl/window_gate.sv
module window_gate #(
  parameter int NUM_CHAINS = 8,
  parameter int SLICE_W    = 4
) (
  input  logic                  shift_en,
  input  logic [SLICE_W-1:0]    slice,
  input  logic [SLICE_W-1:0]    lo,
  input  logic [SLICE_W-1:0]    hi,
  input  logic [NUM_CHAINS-1:0] chain_set,
  input  logic [NUM_CHAINS-1:0] chain_out,
  output logic [NUM_CHAINS-1:0] gated
);
  logic above_lo;
  logic below_hi;
  logic lane_open;

  assign above_lo  = (slice >= lo);
  assign below_hi  = (slice <= hi);
  assign lane_open = shift_en & above_lo & below_hi;

  for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_lane
    assign gated[c] = chain_out[c] & chain_set[c] & lane_open;
  end
endmodule

// File: rtl/bisect_seq.sv
module bisect_seq
  import scan_mask_pkg::*;
#(
  parameter int NUM_CHAINS  = 8,
  parameter int MAX_SLICE   = 7,
  parameter int SLICE_W     = 4,
  parameter int STACK_DEPTH = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_CHAINS-1:0] chain_pick,
  input  logic                  search_start,
  input  logic                  session_done,
  input  logic                  session_fail,
  input  logic                  hit_ready,
  output logic [NUM_CHAINS-1:0] chain_set,
  output logic [SLICE_W-1:0]    lo,
  output logic [SLICE_W-1:0]    hi,
  output logic                  busy,
  output logic                  search_done,
  output logic                  hit_valid,
  output logic [SLICE_W-1:0]    hit_slice
);
  localparam int SP_W = $clog2(STACK_DEPTH + 1);
  localparam int SLOTS = 1 << SP_W;
  localparam logic [SLICE_W-1:0] FIRST = SLICE_W'(1);
  localparam logic [SLICE_W-1:0] LAST  = SLICE_W'(MAX_SLICE);

  seq_state_e state;
  logic [SP_W-1:0]    sp;
  logic [SP_W-1:0]    sp_top;
  logic [SLICE_W-1:0] lo_stk [SLOTS];
  logic [SLICE_W-1:0] hi_stk [SLOTS];
  logic [SLICE_W:0]   span_sum;
  logic [SLICE_W-1:0] mid;
  logic               single;
  logic               idle_like;
  logic               do_start;
  logic               do_split;
  logic               do_hit;
  logic               do_pop;

  assign span_sum  = {1'b0, lo} + {1'b0, hi};
  assign mid       = span_sum[SLICE_W:1];
  assign single    = (lo == hi);
  assign sp_top    = sp - 1'b1;
  assign idle_like = (state == SQ_IDLE) || (state == SQ_DONE);

  assign do_start = idle_like && search_start;
  assign do_split = (state == SQ_RUN) && session_done && session_fail && !single;
  assign do_hit   = (state == SQ_RUN) && session_done && session_fail && single;
  assign do_pop   = ((state == SQ_RUN) && session_done && !session_fail) ||
                    ((state == SQ_REPORT) && hit_ready);

  always_ff @(posedge clk) begin
    if (do_split) begin
      lo_stk[sp] <= mid + 1'b1;
      hi_stk[sp] <= hi;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      lo        <= FIRST;
      hi        <= LAST;
      sp        <= '0;
      chain_set <= '1;
    end else if (do_start) begin
      state     <= SQ_RUN;
      lo        <= FIRST;
      hi        <= LAST;
      sp        <= '0;
      chain_set <= chain_pick;
    end else if (do_split) begin
      hi <= mid;
      sp <= sp + 1'b1;
    end else if (do_hit) begin
      state <= SQ_REPORT;
    end else if (do_pop) begin
      if (sp == '0) begin
        state <= SQ_DONE;
      end else begin
        state <= SQ_RUN;
        lo    <= lo_stk[sp_top];
        hi    <= hi_stk[sp_top];
        sp    <= sp_top;
      end
    end
  end

  assign busy        = (state == SQ_RUN) || (state == SQ_REPORT);
  assign search_done = (state == SQ_DONE);
  assign hit_valid   = (state == SQ_REPORT);
  assign hit_slice   = lo;
endmodule

// File: rtl/scan_mask_unit.sv
module scan_mask_unit #(
  parameter int NUM_CHAINS = 8,
  parameter int MAX_SLICE  = 7,
  localparam int SLICE_W   = $clog2(MAX_SLICE + 2)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_start,
  input  logic                  shift_en,
  input  logic [NUM_CHAINS-1:0] chain_out,
  output logic [NUM_CHAINS-1:0] misr_in,
  input  logic [NUM_CHAINS-1:0] chain_pick,
  input  logic                  search_start,
  input  logic                  session_done,
  input  logic                  session_fail,
  output logic [SLICE_W-1:0]    win_lo,
  output logic [SLICE_W-1:0]    win_hi,
  output logic                  busy,
  output logic                  search_done,
  output logic                  hit_valid,
  input  logic                  hit_ready,
  output logic [SLICE_W-1:0]    hit_slice
);
  localparam int STACK_DEPTH = $clog2(MAX_SLICE) + 1;

  logic [SLICE_W-1:0]    slice;
  logic [NUM_CHAINS-1:0] chain_set;

  slice_counter #(.SLICE_W(SLICE_W)) i_slice_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (load_start),
    .step    (shift_en),
    .slice   (slice)
  );

  window_gate #(.NUM_CHAINS(NUM_CHAINS), .SLICE_W(SLICE_W)) i_window_gate (
    .shift_en  (shift_en),
    .slice     (slice),
    .lo        (win_lo),
    .hi        (win_hi),
    .chain_set (chain_set),
    .chain_out (chain_out),
    .gated     (misr_in)
  );

  bisect_seq #(
    .NUM_CHAINS  (NUM_CHAINS),
    .MAX_SLICE   (MAX_SLICE),
    .SLICE_W     (SLICE_W),
    .STACK_DEPTH (STACK_DEPTH)
  ) i_bisect_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .chain_pick   (chain_pick),
    .search_start (search_start),
    .session_done (session_done),
    .session_fail (session_fail),
    .hit_ready    (hit_ready),
    .chain_set    (chain_set),
    .lo           (win_lo),
    .hi           (win_hi),
    .busy         (busy),
    .search_done  (search_done),
    .hit_valid    (hit_valid),
    .hit_slice    (hit_slice)
  );
endmodule

// File: rtl/scan_mask_chk.sv
module scan_mask_chk #(
  parameter int NUM_CHAINS = 8,
  parameter int MAX_SLICE  = 7,
  parameter int SLICE_W    = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  shift_en,
  input logic [NUM_CHAINS-1:0] chain_out,
  input logic [NUM_CHAINS-1:0] misr_in,
  input logic                  search_start,
  input logic [SLICE_W-1:0]    win_lo,
  input logic [SLICE_W-1:0]    win_hi,
  input logic                  busy,
  input logic                  search_done,
  input logic                  hit_valid,
  input logic                  hit_ready,
  input logic [SLICE_W-1:0]    hit_slice
);
  p_quiet_no_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |-> (misr_in == '0));

  p_only_passes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (misr_in & ~chain_out) == '0);

  p_start_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && search_start) |=> (busy && win_lo == SLICE_W'(1) && win_hi == SLICE_W'(MAX_SLICE)));

  p_window_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (win_lo <= win_hi && win_lo >= SLICE_W'(1) && win_hi <= SLICE_W'(MAX_SLICE)));

  p_done_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && search_done));

  p_hit_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && !hit_ready) |=> (hit_valid && $stable(hit_slice)));

  p_hit_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid |-> (win_lo == win_hi && hit_slice == win_lo));

  p_stall_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && !hit_ready) |=> ($stable(win_lo) && $stable(win_hi)));
endmodule

bind scan_mask_unit scan_mask_chk #(
  .NUM_CHAINS (NUM_CHAINS),
  .MAX_SLICE  (MAX_SLICE),
  .SLICE_W    (SLICE_W)
) i_scan_mask_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .shift_en     (shift_en),
  .chain_out    (chain_out),
  .misr_in      (misr_in),
  .search_start (search_start),
  .win_lo       (win_lo),
  .win_hi       (win_hi),
  .busy         (busy),
  .search_done  (search_done),
  .hit_valid    (hit_valid),
  .hit_ready    (hit_ready),
  .hit_slice    (hit_slice)
);

// File: tb/test_scan_mask_unit.sv
module test_scan_mask_unit;
  localparam int NC = 8;
  localparam int MS = 7;
  localparam int SW = 4;
  localparam int NROWS = 6;
  // {error slices, chain pick, expected sessions, expected hit slices}
  localparam logic [31:0] VEC [NROWS] = '{
    {8'h08, 8'h18, 8'd7,  8'h08},
    {8'h00, 8'h18, 8'd1,  8'h00},
    {8'h82, 8'h18, 8'd9,  8'h82},
    {8'h60, 8'h18, 8'd7,  8'h60},
    {8'hFE, 8'h08, 8'd13, 8'hFE},
    {8'h10, 8'h10, 8'd1,  8'h00}
  };

  logic clk = 0;
  logic rst_n = 0;
  logic load_start = 0, shift_en = 0, search_start = 0;
  logic session_done = 0, session_fail = 0, hit_ready = 1;
  logic [NC-1:0] chain_out = '0, chain_pick = '0, misr_in;
  logic [SW-1:0] win_lo, win_hi, hit_slice;
  logic busy, search_done, hit_valid;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #5 clk = ~clk;

  scan_mask_unit #(.NUM_CHAINS(NC), .MAX_SLICE(MS)) i_scan_mask_unit (
    .clk(clk), .rst_n(rst_n), .load_start(load_start), .shift_en(shift_en),
    .chain_out(chain_out), .misr_in(misr_in), .chain_pick(chain_pick),
    .search_start(search_start), .session_done(session_done),
    .session_fail(session_fail), .win_lo(win_lo), .win_hi(win_hi),
    .busy(busy), .search_done(search_done), .hit_valid(hit_valid),
    .hit_ready(hit_ready), .hit_slice(hit_slice)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      summary();
    end
  end

  // One session: restart index, shift MS slices; errors on chain 3, noise on chain 0.
  task automatic run_session(input logic [7:0] err);
    logic fail = 0;
    load_start = 1;
    @(negedge clk);
    load_start = 0;
    for (int s = 1; s <= MS; s++) begin
      shift_en  = 1;
      chain_out = 8'h01 | (err[s] ? 8'h08 : 8'h00);
      #1;
      fail = fail | (|misr_in);
      @(negedge clk);
    end
    shift_en = 0;
    chain_out = '0;
    session_fail = fail;
    session_done = 1;
    @(negedge clk);
    session_done = 0;
    session_fail = 0;
  endtask

  task automatic begin_search(input logic [7:0] pick);
    chain_pick = pick;
    search_start = 1;
    @(negedge clk);
    search_start = 0;
  endtask

  task automatic run_search(input logic [7:0] err, input logic [7:0] pick,
                            output int sess, output logic [7:0] hits, output bit ordered);
    int last = 0;
    sess = 0;
    hits = '0;
    ordered = 1;
    begin_search(pick);
    for (int g = 0; g < 200; g++) begin
      if (search_done) break;
      if (hit_valid) begin
        if (int'(hit_slice) <= last) ordered = 0;
        last = int'(hit_slice);
        hits[hit_slice[2:0]] = 1'b1;
        @(negedge clk);
      end else begin
        run_session(err);
        sess++;
      end
    end
  endtask

  initial begin
    int sess;
    logic [7:0] hits;
    bit ordered;
    logic [NC-1:0] acc;

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk(win_lo == 1, "R1 win_lo", win_lo, 1);
    chk(win_hi == MS, "R1 win_hi", win_hi, MS);
    chk(!busy && !search_done && !hit_valid, "R1 flags", {busy, search_done, hit_valid}, 0);
    // R2 no shift -> zero
    chain_out = '1;
    #1;
    chk(misr_in == '0, "R2 no shift", misr_in, 0);

    // R1/R2: idle, all chains selected, full window
    load_start = 1;
    @(negedge clk);
    load_start = 0;
    acc = '1;
    for (int s = 1; s <= MS; s++) begin
      shift_en = 1;
      #1;
      acc = acc & misr_in;
      @(negedge clk);
    end
    chk(acc == '1, "R1 all chains open in window", acc, 255);
    #1;
    chk(misr_in == '0, "R2 slice above hi", misr_in, 0);
    @(negedge clk);
    // R3 coincident restart and shift: this cycle uses old index (9, outside window)
    load_start = 1;
    #1;
    chk(misr_in == '0, "R3 coincident uses old index", misr_in, 0);
    @(negedge clk);
    load_start = 0;
    #1;
    chk(misr_in == '1, "R3 next shift is slice 1", misr_in, 255);
    @(negedge clk);
    shift_en = 0;
    chain_out = '0;

    // table-driven searches: R2 R4 R5 R6 R9
    for (int r = 0; r < NROWS; r++) begin
      run_search(VEC[r][31:24], VEC[r][23:16], sess, hits, ordered);
      chk(sess == int'(VEC[r][15:8]), "R9 session count", sess, int'(VEC[r][15:8]));
      chk(hits == VEC[r][7:0], "R2 R9 hit slices", hits, int'(VEC[r][7:0]));
      chk(ordered, "R9 ascending hits", 0, 1);
      chk(search_done && !busy, "R6 done at empty stack", {search_done, busy}, 2);
    end

    // R8: session_done while done is ignored
    session_done = 1;
    session_fail = 1;
    @(negedge clk);
    session_done = 0;
    session_fail = 0;
    chk(search_done && !busy, "R8 ignored when done", {search_done, busy}, 2);

    // R4 R5 R7 R8 R6 with back-pressure; error at slice 2
    hit_ready = 0;
    begin_search(8'h08);
    chk(busy && !search_done && win_lo == 1 && win_hi == MS, "R4 start window", win_hi, MS);
    run_session(8'h04);
    chk(win_lo == 1 && win_hi == 4, "R5 split to lower half", win_hi, 4);
    for (int g = 0; g < 10 && !hit_valid; g++) run_session(8'h04);
    chk(hit_valid && hit_slice == 2, "R7 hit slice", hit_slice, 2);
    repeat (3) @(negedge clk);
    chk(hit_valid && hit_slice == 2, "R7 held under back-pressure", hit_slice, 2);
    session_done = 1;
    @(negedge clk);
    session_done = 0;
    chk(hit_valid && win_lo == 2 && win_hi == 2, "R8 ignored while reporting", win_lo, 2);
    hit_ready = 1;
    @(negedge clk);
    chk(!hit_valid && win_lo == 3 && win_hi == 4, "R6 pop latest range", win_lo, 3);
    for (int g = 0; g < 20 && !search_done; g++) begin
      if (hit_valid) @(negedge clk);
      else run_session(8'h04);
    end
    chk(search_done && !busy, "R6 drained", {search_done, busy}, 2);

    summary();
  end
endmodule